// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a virtual address to a physical page after a translation miss. It walks a radix tree of four table levels held in ordinary memory. Each level is selected by its own 9-bit slice of the virtual page number, and the tree starts from a root page number given on an input. The walker reads one 64-bit entry per level over a simple request/acknowledge memory port. At the last level it returns either a 40-bit physical page number together with the full physical address, or a fault code.

Access rights add up along the path. Any entry on the way can forbid writes, forbid user-mode access or forbid instruction fetch, and such a fault is reported with a code of its own, separate from the code for a missing entry. While it walks, the walker keeps the reference bit of each entry it passes through, and the dirty bit of the final entry on writes, up to date in memory. It writes an entry back only when one of those bits actually changes. Only one walk is in flight at a time.

Top module: `pgwalk_top`

## Requirements
- R1: The virtual address is 48 bits: bits 11:0 are the page offset, and bits 47:39, 38:30, 29:21 and 20:12 index the first (root) through fourth level. The entry for a level is read at byte address {table page number, 9-bit index, 3'b000}.
- R2: The first read uses `root_ppn` as the table page number. Every later table, and the final page, takes its 40-bit page number from bits 51:12 of the entry read one level above. A successful walk reads exactly four entries.
- R3: An entry with bit 0 (present) clear ends the walk with fault code 1. No further memory access is made, and this check takes precedence over the rights checks.
- R4: Fault code 2 ends the walk at the first entry where one of these holds: the access kind is write (`req_kind`=1) and bit 1 is clear; `req_user`=1 and bit 2 is clear; the access kind is fetch (`req_kind`=2) and bit 63 is set. Read is `req_kind`=0. A faulting entry is never written back.
- R5: Every present entry that passes the rights checks gets bit 5 set. It is written back to its own address only when this changes its value, and no other bit changes except as in R6.
- R6: On a write access, bit 6 of the fourth-level entry is set. Bit 6 of the upper-level entries is never changed.
- R7: A write-back completes (is acknowledged) before the read of the next level begins, and each write goes to the address of the entry just read.
- R8: `done` pulses for one cycle with `done_fault` (0 = success). On success `done_ppn` is the leaf page number and `done_paddr` is {`done_ppn`, offset}. On a fault `done_ppn` is zero.
- R9: A request is taken when `req_valid` is high and `busy` is low. `busy` stays high from the next cycle through the `done` cycle, and requests made while busy have no effect.
- R10: After reset `busy`, `done` and `mem_req` are low.
- R11: `mem_req` stays high with stable `mem_addr` and `mem_we` until the cycle in which `mem_ack` is seen. Read data is taken from `mem_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk |
| req_vaddr | input | 48 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_user | input | 1 | 1 when the access is made in user mode |
| root_ppn | input | 40 | Page number of the root table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 2 | 0 none, 1 not present, 2 protection |
| done_ppn | output | 40 | Translated page number |
| done_paddr | output | 52 | Translated physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for an entry write-back |
| mem_addr | output | 52 | Byte address of the entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | Memory accepted or answered the access |
| mem_rdata | input | 64 | Entry value read |

## Verification
The walks cover several separate table paths. One path is fresh (all reference bits clear) and is walked by a read, then again by the same read, then by writes and a fetch: this separates first-touch write-backs from the silent repeat walks, and leaf-only dirty marking from upper-level marking. Other paths place a missing entry at the second level, a missing write right at the root, a missing user right at the root, and a no-execute leaf. These show whether the walk stops at the right depth with the right code. A path whose root entry needs a reference update but whose next entry is absent shows that the write-back finishes before the fault. A request made during a walk checks that the walk in flight is left unchanged.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int ENT_W = 64;

  // entry bit positions
  localparam int BIT_P  = 0;
  localparam int BIT_WR = 1;
  localparam int BIT_US = 2;
  localparam int BIT_RF = 5;
  localparam int BIT_DT = 6;
  localparam int BIT_NX = 63;

  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_ABSENT = 2'd1;
  localparam logic [1:0] FLT_PROT   = 2'd2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_WR, S_DONE
  } wstate_e;

  // access rights denied by one entry
  function automatic logic perm_violation(logic [ENT_W-1:0] e, acc_e k, logic usr);
    logic bad;
    bad = 1'b0;
    if (k == ACC_WRITE && !e[BIT_WR]) bad = 1'b1;
    if (usr && !e[BIT_US])            bad = 1'b1;
    if (k == ACC_FETCH && e[BIT_NX])  bad = 1'b1;
    return bad;
  endfunction

  // entry value after the walk has touched it
  function automatic logic [ENT_W-1:0] mark_entry(logic [ENT_W-1:0] e, acc_e k, logic leaf);
    logic [ENT_W-1:0] r;
    r = e;
    r[BIT_RF] = 1'b1;
    if (leaf && k == ACC_WRITE) r[BIT_DT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pgw_idx_sel.sv
module pgw_idx_sel #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int LVL_W  = 2
) (
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  logic [LVL_W-1:0]        level,
  output logic [IDX_W-1:0]        idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign idx = slice[level];
endmodule

// File: rtl/pgw_entry_eval.sv
module pgw_entry_eval
  import pgw_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  acc_e             kind,
  input  logic             user,
  input  logic             leaf,
  output logic             absent,
  output logic             prot,
  output logic             need_wb,
  output logic [ENT_W-1:0] updated
);
  always_comb begin
    absent  = !entry[BIT_P];
    prot    = perm_violation(entry, kind, user);
    updated = mark_entry(entry, kind, leaf);
    need_wb = (updated != entry);
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [LEVELS*IDX_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]                  req_kind,
  input  logic                        req_user,
  input  logic [PPN_W-1:0]            root_ppn,
  output logic                        busy,
  output logic                        done,
  output logic [1:0]                  done_fault,
  output logic [PPN_W-1:0]            done_ppn,
  output logic [PPN_W+OFF_W-1:0]      done_paddr,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [PPN_W+OFF_W-1:0]      mem_addr,
  output logic [63:0]                 mem_wdata,
  input  logic                        mem_ack,
  input  logic [63:0]                 mem_rdata
);
  localparam int VPN_W = LEVELS * IDX_W;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ESZ_W = OFF_W - IDX_W;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  wstate_e          state;
  logic [LVL_W-1:0] lvl;
  logic [VA_W-1:0]  va_q;
  acc_e             kind_q;
  logic             user_q;
  logic [PPN_W-1:0] base_q;
  logic [PPN_W-1:0] ppn_q;
  logic [1:0]       fault_q;
  logic [ENT_W-1:0] ent_q;
  logic [ENT_W-1:0] wb_q;

  logic [IDX_W-1:0] cur_idx;
  logic             is_leaf;
  logic             ev_absent, ev_prot, ev_need_wb;
  logic [ENT_W-1:0] ev_updated;
  logic [PPN_W-1:0] ent_ppn;

  // named events for the assertions
  logic walk_start, lvl_absent, lvl_prot, lvl_wb, lvl_adv;

  pgw_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W)) idx_i (
    .vpn   (va_q[VA_W-1:OFF_W]),
    .level (lvl),
    .idx   (cur_idx)
  );

  pgw_entry_eval eval_i (
    .entry   (ent_q),
    .kind    (kind_q),
    .user    (user_q),
    .leaf    (is_leaf),
    .absent  (ev_absent),
    .prot    (ev_prot),
    .need_wb (ev_need_wb),
    .updated (ev_updated)
  );

  assign is_leaf = (lvl == LAST_LVL);
  assign ent_ppn = ent_q[OFF_W +: PPN_W];

  assign walk_start = (state == S_IDLE) && req_valid;
  assign lvl_absent = (state == S_CHK) && ev_absent;
  assign lvl_prot   = (state == S_CHK) && !ev_absent && ev_prot;
  assign lvl_wb     = (state == S_CHK) && !ev_absent && !ev_prot && ev_need_wb;
  assign lvl_adv    = ((state == S_CHK) && !ev_absent && !ev_prot && !ev_need_wb) ||
                      ((state == S_WR) && mem_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      lvl     <= '0;
      va_q    <= '0;
      kind_q  <= ACC_READ;
      user_q  <= 1'b0;
      base_q  <= '0;
      ppn_q   <= '0;
      fault_q <= FLT_NONE;
      ent_q   <= '0;
      wb_q    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (walk_start) begin
            va_q    <= req_vaddr;
            kind_q  <= acc_e'(req_kind);
            user_q  <= req_user;
            base_q  <= root_ppn;
            lvl     <= '0;
            ppn_q   <= '0;
            fault_q <= FLT_NONE;
            state   <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ack) begin
            ent_q <= mem_rdata;
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (lvl_absent) begin
            fault_q <= FLT_ABSENT;
            state   <= S_DONE;
          end else if (lvl_prot) begin
            fault_q <= FLT_PROT;
            state   <= S_DONE;
          end else if (lvl_wb) begin
            wb_q  <= ev_updated;
            state <= S_WR;
          end
        end
        S_WR: ;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (lvl_adv) begin
        if (is_leaf) begin
          ppn_q <= ent_ppn;
          state <= S_DONE;
        end else begin
          base_q <= ent_ppn;
          lvl    <= lvl + 1'b1;
          state  <= S_RD;
        end
      end
    end
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign done_fault = fault_q;
  assign done_ppn   = ppn_q;
  assign done_paddr = {ppn_q, va_q[OFF_W-1:0]};
  assign mem_req    = (state == S_RD) || (state == S_WR);
  assign mem_we     = (state == S_WR);
  assign mem_addr   = {base_q, cur_idx, {ESZ_W{1'b0}}};
  assign mem_wdata  = wb_q;

  // ---------------- assertions ----------------
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)) // R11
    else $error("memory request dropped or changed before ack");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done) // R9
    else $error("activity while not busy");

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault != FLT_NONE |-> done_ppn == '0) // R8
    else $error("fault result carries a page number");

  AST_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_absent |=> done && done_fault == FLT_ABSENT) // R3
    else $error("absent entry did not end the walk");

  AST_PROT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_prot |=> done && done_fault == FLT_PROT && !mem_req) // R4
    else $error("rights failure did not end the walk");

  AST_WB_ONLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (((mem_wdata ^ ent_q) & ~((64'd1 << BIT_RF) | (64'd1 << BIT_DT))) == '0)
                          && (mem_wdata != ent_q)) // R5
    else $error("write-back changes wrong bits or nothing");

  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> mem_addr == $past(mem_addr)) // R7
    else $error("write-back to a different entry");

  AST_WB_BEFORE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && $past(mem_req && mem_we) |-> $past(mem_ack)) // R7
    else $error("next read started before write-back ack");

endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [47:0]  req_vaddr = '0;
  logic [1:0]   req_kind = '0;
  logic         req_user = 1'b0;
  logic [39:0]  root_ppn = 40'h10;
  logic         busy, done;
  logic [1:0]   done_fault;
  logic [39:0]  done_ppn;
  logic [51:0]  done_paddr;
  logic         mem_req, mem_we;
  logic [51:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic         mem_ack = 1'b0;
  logic [63:0]  mem_rdata = '0;

  always #2 clk = ~clk; // 250 MHz

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .root_ppn(root_ppn),
    .busy(busy), .done(done), .done_fault(done_fault), .done_ppn(done_ppn),
    .done_paddr(done_paddr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [51:0]];
  int          rd_cnt, wr_cnt, ord_err;
  logic [51:0] last_rd;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
        if (mem_addr != last_rd) ord_err++;
      end else begin
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
        rd_cnt++;
        last_rd = mem_addr;
      end
      mem_ack = 1'b1;
    end
  end

  // entry flag masks
  localparam logic [63:0] FP = 64'd1;
  localparam logic [63:0] FW = 64'd2;
  localparam logic [63:0] FU = 64'd4;
  localparam logic [63:0] FA = 64'd32;
  localparam logic [63:0] FD = 64'd64;
  localparam logic [63:0] FX = 64'd1 << 63;

  function automatic logic [51:0] eaddr(logic [39:0] ppn, logic [8:0] idx);
    return {ppn, idx, 3'b000};
  endfunction

  function automatic logic [63:0] mk(logic [39:0] ppn, logic [63:0] flags);
    return flags | {12'd0, ppn, 12'd0};
  endfunction

  // ---------------- counters and checks ----------------
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  logic walk_ok;

  task automatic walk(input logic [47:0] va, input logic [1:0] k, input logic u);
    rd_cnt = 0; wr_cnt = 0; ord_err = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 400 && !done; t++) @(negedge clk);
    walk_ok = done;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R8 walk timeout: actual done=0 expected done=1");
    end
  endtask

  // ---------------- vectors ----------------
  localparam logic [47:0] VA_A = {9'd1, 9'd2, 9'd3, 9'd4, 12'h123};
  localparam logic [47:0] VA_B = {9'd5, 9'd0, 9'd0, 9'd0, 12'hFFF};
  localparam logic [47:0] VA_C = {9'd6, 9'd1, 9'd0, 9'd0, 12'h000};
  localparam logic [47:0] VA_D = {9'd7, 9'd0, 9'd0, 9'd0, 12'h040};
  localparam logic [47:0] VA_E = {9'd8, 9'd0, 9'd0, 9'd0, 12'h800};

  typedef struct packed {
    logic [47:0] va;
    logic [1:0]  kind;
    logic        usr;
    logic [1:0]  flt;
    logic [39:0] ppn;
    logic [2:0]  nrd;
    logic [2:0]  nwr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{VA_A, 2'd0, 1'b1, 2'd0, 40'hABCDE, 3'd4, 3'd4}, // R5 first touch
    '{VA_A, 2'd0, 1'b1, 2'd0, 40'hABCDE, 3'd4, 3'd0}, // R5 no change
    '{VA_A, 2'd1, 1'b0, 2'd0, 40'hABCDE, 3'd4, 3'd1}, // R6 dirty leaf
    '{VA_A, 2'd1, 1'b0, 2'd0, 40'hABCDE, 3'd4, 3'd0}, // R6 already dirty
    '{VA_A, 2'd2, 1'b1, 2'd0, 40'hABCDE, 3'd4, 3'd0}, // R4 fetch allowed
    '{VA_B, 2'd1, 1'b1, 2'd2, 40'h0,     3'd1, 3'd0}, // R4 no write at root
    '{VA_B, 2'd0, 1'b1, 2'd0, 40'h777,   3'd4, 3'd0}, // R2 read path B
    '{VA_B, 2'd2, 1'b0, 2'd2, 40'h0,     3'd4, 3'd0}, // R4 no-execute leaf
    '{VA_C, 2'd0, 1'b0, 2'd1, 40'h0,     3'd2, 3'd0}, // R3 absent level 2
    '{VA_C, 2'd0, 1'b1, 2'd2, 40'h0,     3'd1, 3'd0}, // R4 no user at root
    '{VA_D, 2'd0, 1'b0, 2'd1, 40'h0,     3'd2, 3'd1}, // R7 write-back then absent
    '{VA_E, 2'd1, 1'b0, 2'd0, 40'h5,     3'd4, 3'd1}  // R6 dirty only
  };

  initial begin
    // path A (fresh)
    mem[eaddr(40'h10, 9'd1)] = mk(40'h11, FP|FW|FU);
    mem[eaddr(40'h11, 9'd2)] = mk(40'h12, FP|FW|FU);
    mem[eaddr(40'h12, 9'd3)] = mk(40'h13, FP|FW|FU);
    mem[eaddr(40'h13, 9'd4)] = mk(40'hABCDE, FP|FW|FU);
    // path B
    mem[eaddr(40'h10, 9'd5)] = mk(40'h14, FP|FU|FA);
    mem[eaddr(40'h14, 9'd0)] = mk(40'h15, FP|FW|FU|FA);
    mem[eaddr(40'h15, 9'd0)] = mk(40'h16, FP|FW|FU|FA);
    mem[eaddr(40'h16, 9'd0)] = mk(40'h777, FP|FW|FU|FA|FX);
    // path C
    mem[eaddr(40'h10, 9'd6)] = mk(40'h17, FP|FW|FA);
    // path D
    mem[eaddr(40'h10, 9'd7)] = mk(40'h18, FP|FW|FU);
    // path E
    mem[eaddr(40'h10, 9'd8)] = mk(40'h19, FP|FW|FU|FA);
    mem[eaddr(40'h19, 9'd0)] = mk(40'h1A, FP|FW|FU|FA);
    mem[eaddr(40'h1A, 9'd0)] = mk(40'h1B, FP|FW|FU|FA);
    mem[eaddr(40'h1B, 9'd0)] = mk(40'h5, FP|FW|FU|FA);

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", 64'(busy), 64'd0);
    chk("R10", "done", 64'(done), 64'd0);
    chk("R10", "mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      walk(VEC[i].va, VEC[i].kind, VEC[i].usr);
      if (walk_ok) begin
        chk("R3 R4 fault", $sformatf("vec%0d code", i), 64'(done_fault), 64'(VEC[i].flt));
        chk("R2 R8 ppn", $sformatf("vec%0d ppn", i), 64'(done_ppn), 64'(VEC[i].ppn));
        chk("R8 paddr", $sformatf("vec%0d paddr", i), 64'(done_paddr),
            64'({VEC[i].ppn, VEC[i].va[11:0]}));
        chk("R1 R3 reads", $sformatf("vec%0d reads", i), 64'(rd_cnt), 64'(VEC[i].nrd));
        chk("R5 writes", $sformatf("vec%0d writes", i), 64'(wr_cnt), 64'(VEC[i].nwr));
        chk("R7 order", $sformatf("vec%0d write addr", i), 64'(ord_err), 64'd0);
      end
      if (i == 0) begin
        // R5 reference bits set, nothing else
        chk("R5", "root entry A", mem[eaddr(40'h10, 9'd1)], mk(40'h11, FP|FW|FU|FA));
        chk("R5", "leaf entry A", mem[eaddr(40'h13, 9'd4)], mk(40'hABCDE, FP|FW|FU|FA));
      end
      if (i == 2) begin
        chk("R6", "leaf dirty", mem[eaddr(40'h13, 9'd4)], mk(40'hABCDE, FP|FW|FU|FA|FD));
        chk("R6", "upper untouched", mem[eaddr(40'h12, 9'd3)], mk(40'h13, FP|FW|FU|FA));
      end
      if (i == 5) begin
        chk("R4", "root B not written", mem[eaddr(40'h10, 9'd5)], mk(40'h14, FP|FU|FA));
      end
      if (i == 10) begin
        chk("R7", "root D reference", mem[eaddr(40'h10, 9'd7)], mk(40'h18, FP|FW|FU|FA));
      end
    end

    // R8 done is a single-cycle pulse
    @(negedge clk);
    chk("R8", "done after pulse", 64'(done), 64'd0);
    chk("R9", "busy after result", 64'(busy), 64'd0);

    // R9 request during a walk is ignored
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = VA_E; req_kind = 2'd0; req_user = 1'b0;
    @(negedge clk);
    req_vaddr = VA_B; req_kind = 2'd1; req_user = 1'b1;
    chk("R9", "busy during walk", 64'(busy), 64'd1);
    for (int t = 0; t < 400 && !done; t++) @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "ignored request fault", 64'(done_fault), 64'd0);
    chk("R9", "ignored request ppn", 64'(done_ppn), 64'h5);
    chk("R9", "busy with done", 64'(busy), 64'd1);
    @(negedge clk);
    @(negedge clk);
    for (int t = 0; t < 400 && busy; t++) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule